// File: doc/BRIEF.md
# XNOR Chain Board-Test Controller

This block gives a chip a board-level connectivity test. Once the test mode is armed, every member of a parity chain feeds one output bit. Flipping any single member flips that bit. A tester can therefore check each pin's solder joint with nothing more than a voltmeter on one shared output pin. The chain path has no clock: it is a combinational parity network from the pins to the output.

The mode is armed from two strap inputs, which are ordinary functional pins at other times. Their level is captured at the rising edge of the active-low external reset: both low arms the mode, and any other combination disarms it. A power-on reset always disarms the mode and overrides the external reset. While the mode is armed, the two straps also join the chain, and the shared output pin carries the chain result in place of its normal function.

Top module: `xct_top`

## Requirements
- R1: At a low-to-high transition of `ext_rst_n` with `por` low and both `strap_a` and `strap_b` low, `test_active` becomes 1.
- R2: At a low-to-high transition of `ext_rst_n` with `por` low and `strap_a` or `strap_b` high, `test_active` becomes 0. Strap changes while `ext_rst_n` stays high do not change `test_active`.
- R3: While `por` is high, `test_active` is 0, even if `ext_rst_n` rises with both straps low.
- R4: In test mode, `strap_a` and `strap_b` are chain members, so toggling either one toggles `chain_out`. Outside test mode they have no effect on `chain_out` or `pin_out`.
- R5: In test mode, `chain_out` equals the XOR of all bits of `chain_in` and both straps. Changing any single member therefore toggles it.
- R6: In test mode, with every chain member low, `chain_out` is 0.
- R7: Outside test mode, `pin_sel` is 0, `chain_out` is 0, and `pin_out` equals `pin_func` for any value of `chain_in`.
- R8: In test mode, `pin_sel` is 1 and `pin_out` equals `chain_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| chain_in | input | N_CHAIN | Pins that are members of the parity chain |
| strap_a | input | 1 | First mode strap; also a chain member while in test mode |
| strap_b | input | 1 | Second mode strap; also a chain member while in test mode |
| ext_rst_n | input | 1 | Active-low external reset; its rising edge latches the mode |
| por | input | 1 | Power-on reset, active high; forces the mode off |
| pin_func | input | 1 | Normal-function value for the shared output pin |
| chain_out | output | 1 | Parity of all chain members; 0 outside test mode |
| test_active | output | 1 | Test mode flag |
| pin_sel | output | 1 | 1 routes the chain result onto the shared pin |
| pin_out | output | 1 | Value driven on the shared output pin |

## Verification
The hardest state to reach is a test mode in which the straps have moved away from the levels that armed it. Reaching it shows that the straps count as chain members without disturbing the latched flag. The bench arms the mode with both straps low and keeps `ext_rst_n` high. It then raises each strap in turn and checks that the chain output flips and the flag holds. A power-on pulse delivered while the external reset rises with both straps low also exercises the priority of the power-on reset.

// File: rtl/xct_pkg.sv
package xct_pkg;
   // Ways of building the parity network
   typedef enum int {
      XCT_SERIAL_XNOR = 0,
      XCT_XOR_TREE    = 1
   } xct_style_e;

   localparam int XCT_NUM_STRAPS = 2;
endpackage

// File: rtl/xct_mode_latch.sv
module xct_mode_latch (
   input  logic strap_a,
   input  logic strap_b,
   input  logic ext_rst_n,
   input  logic por,
   output logic mode_q
);
   logic arm;

   assign arm = ~strap_a & ~strap_b;

   // Rising external reset captures the strap decision; power-on reset wins
   always_ff @(posedge ext_rst_n or posedge por) begin
      if (por) mode_q <= 1'b0;
      else     mode_q <= arm;
   end
endmodule

// File: rtl/xct_parity_net.sv
module xct_parity_net
   import xct_pkg::*;
#(
   parameter int         N_MEM = 98,
   parameter xct_style_e STYLE = XCT_SERIAL_XNOR,
   parameter int         GRP   = 8
) (
   input  logic [N_MEM-1:0] mem,
   output logic             par
);
   localparam int N_GRP = (N_MEM + GRP - 1) / GRP;
   localparam int N_PAD = N_GRP * GRP;
   // A serial XNOR string of N links adds one inversion per gate
   localparam bit CORR  = ((N_MEM - 1) % 2) == 1;

   generate
      if (STYLE == XCT_SERIAL_XNOR) begin : g_serial
         logic [N_MEM-1:0] link;
         assign link[0] = mem[0];
         for (genvar i = 1; i < N_MEM; i++) begin : g_link
            assign link[i] = ~(link[i-1] ^ mem[i]);
         end
         assign par = link[N_MEM-1] ^ CORR;
      end else begin : g_tree
         logic [N_PAD-1:0] pad;
         logic [N_GRP-1:0] part;
         assign pad = {{(N_PAD-N_MEM){1'b0}}, mem};
         for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            assign part[g] = ^pad[g*GRP +: GRP];
         end
         assign par = ^part;
      end
   endgenerate
endmodule

// File: rtl/xct_pin_mux.sv
module xct_pin_mux (
   input  logic sel,
   input  logic test_val,
   input  logic func_val,
   output logic pin
);
   always_comb begin
      pin = sel ? test_val : func_val;
   end
endmodule

// File: rtl/xct_top.sv
module xct_top
   import xct_pkg::*;
#(
   parameter int         N_CHAIN = 96,
   parameter xct_style_e STYLE   = XCT_SERIAL_XNOR,
   parameter int         GRP     = 8
) (
   input  logic [N_CHAIN-1:0] chain_in,
   input  logic               strap_a,
   input  logic               strap_b,
   input  logic               ext_rst_n,
   input  logic               por,
   input  logic               pin_func,
   output logic               chain_out,
   output logic               test_active,
   output logic               pin_sel,
   output logic               pin_out
);
   localparam int N_MEM = N_CHAIN + XCT_NUM_STRAPS;

   if (N_CHAIN < 1) begin : g_bad_width
      $error("xct_top: N_CHAIN must be at least 1");
   end
   if (GRP < 2) begin : g_bad_grp
      $error("xct_top: GRP must be at least 2");
   end

   logic             mode_q;
   logic [N_MEM-1:0] members;
   logic             par;

   xct_mode_latch u_latch (
      .strap_a  (strap_a),
      .strap_b  (strap_b),
      .ext_rst_n(ext_rst_n),
      .por      (por),
      .mode_q   (mode_q)
   );

   // Straps join the chain only once the mode is armed
   assign members = {strap_b & mode_q, strap_a & mode_q, chain_in};

   xct_parity_net #(.N_MEM(N_MEM), .STYLE(STYLE), .GRP(GRP)) u_net (
      .mem(members),
      .par(par)
   );

   // Hold the chain result quiet outside test mode
   assign chain_out   = par & mode_q;
   assign test_active = mode_q;
   assign pin_sel     = mode_q;

   xct_pin_mux u_mux (
      .sel     (pin_sel),
      .test_val(chain_out),
      .func_val(pin_func),
      .pin     (pin_out)
   );
endmodule

// File: rtl/xct_checker.sv
module xct_checker #(
   parameter int N_CHAIN = 96
) (
   input logic [N_CHAIN-1:0] chain_in,
   input logic               strap_a,
   input logic               strap_b,
   input logic               ext_rst_n,
   input logic               por,
   input logic               pin_func,
   input logic               chain_out,
   input logic               test_active,
   input logic               pin_sel,
   input logic               pin_out
);
   logic exp_mode;
   logic seen_por;

   always_ff @(posedge ext_rst_n or posedge por) begin
      if (por) begin
         exp_mode <= 1'b0;
         seen_por <= 1'b1;
      end else begin
         exp_mode <= !(strap_a || strap_b);
      end
   end

   always @(negedge por) begin
      AST_POR_EXIT: assert (!test_active);   // R3
   end

   always @(negedge ext_rst_n) begin
      if (!por && seen_por) begin
         AST_MODE_LATCH: assert (test_active == exp_mode);   // R1 R2
         if (!test_active) begin
            AST_QUIET_OFF: assert (!pin_sel && !chain_out && pin_out == pin_func);   // R7
         end else begin
            AST_SEL_ON: assert (pin_sel && pin_out == chain_out);   // R8
            if (chain_in == '0 && !strap_a && !strap_b) begin
               AST_ALL_LOW: assert (!chain_out);   // R6
            end
         end
      end
   end
endmodule

bind xct_top xct_checker #(.N_CHAIN(N_CHAIN)) u_chk (
   .chain_in   (chain_in),
   .strap_a    (strap_a),
   .strap_b    (strap_b),
   .ext_rst_n  (ext_rst_n),
   .por        (por),
   .pin_func   (pin_func),
   .chain_out  (chain_out),
   .test_active(test_active),
   .pin_sel    (pin_sel),
   .pin_out    (pin_out)
);

// File: tb/tb_xct_top.sv
module tb_xct_top;
   localparam int N = 96;

   logic         clk = 1'b0;
   logic [N-1:0] chain_in = '0;
   logic         strap_a = 1'b1, strap_b = 1'b1, ext_rst_n = 1'b0, por = 1'b1, pin_func = 1'b0;
   logic         chain_out, test_active, pin_sel, pin_out;
   int           n_chk = 0, n_fail = 0;
   logic         m_mode = 1'b0;
   logic         prev;

   always #2 clk = ~clk;

   xct_top #(.N_CHAIN(N)) dut (
      .chain_in(chain_in), .strap_a(strap_a), .strap_b(strap_b),
      .ext_rst_n(ext_rst_n), .por(por), .pin_func(pin_func),
      .chain_out(chain_out), .test_active(test_active),
      .pin_sel(pin_sel), .pin_out(pin_out)
   );

   function automatic logic exp_chain(logic [N-1:0] v, logic a, logic b, logic m);
      return m ? (^v ^ a ^ b) : 1'b0;
   endfunction

   function automatic logic exp_pin(logic [N-1:0] v, logic a, logic b, logic m, logic f);
      return m ? exp_chain(v, a, b, m) : f;
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   task automatic check_all(string req);
      check({req, " mode"}, test_active, m_mode);
      check({req, " sel"},  pin_sel, m_mode);
      check({req, " chain"}, chain_out, exp_chain(chain_in, strap_a, strap_b, m_mode));
      check({req, " pin"},  pin_out, exp_pin(chain_in, strap_a, strap_b, m_mode, pin_func));
   endtask

   // Drop and raise the external reset with the given strap levels
   task automatic rst_pulse(logic a, logic b);
      @(negedge clk); strap_a = a; strap_b = b;
      @(negedge clk); ext_rst_n = 1'b0;
      @(negedge clk); ext_rst_n = 1'b1;
      if (!por) m_mode = !a && !b;
      settle();
   endtask

   initial begin
      #400000;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      // Reset state under power-on reset
      settle();
      check_all("R3 reset");
      // R3: rising external reset with straps low cannot arm while por is high
      strap_a = 1'b0; strap_b = 1'b0;
      @(negedge clk); ext_rst_n = 1'b1;
      settle();
      check("R3 por priority", test_active, 1'b0);
      @(negedge clk); por = 1'b0;
      settle();
      check("R3 after por", test_active, 1'b0);
      // R7 / R4: outside mode, chain and straps leave the pin alone
      pin_func = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); chain_in = {$urandom, $urandom, $urandom};
         strap_a = $urandom; strap_b = $urandom;
         settle();
         check("R7 off pin", pin_out, 1'b1);
         check("R4 off chain", chain_out, 1'b0);
      end
      // R2: one strap low is not enough
      @(negedge clk); chain_in = '0;
      rst_pulse(1'b0, 1'b1);
      check_all("R2 one strap high");
      // R1: enter
      rst_pulse(1'b0, 1'b0);
      check_all("R1 entry");
      check("R6 all low", chain_out, 1'b0);
      check("R8 sel", pin_sel, 1'b1);
      // R4: straps are chain members in mode and do not change the flag
      prev = chain_out;
      @(negedge clk); strap_a = 1'b1; settle();
      check("R4 strap_a toggles", chain_out, ~prev);
      check("R2 flag holds", test_active, 1'b1);
      prev = chain_out;
      @(negedge clk); strap_b = 1'b1; settle();
      check("R4 strap_b toggles", chain_out, ~prev);
      check_all("R8 pin");
      @(negedge clk); strap_a = 1'b0; strap_b = 1'b0; settle();
      check("R6 all low again", chain_out, 1'b0);
      // R5: walk high in descending order, then low in ascending order
      for (int i = N - 1; i >= 0; i--) begin
         prev = chain_out;
         @(negedge clk); chain_in[i] = 1'b1; settle();
         check("R5 walk up", chain_out, ~prev);
      end
      check("R5 all high", chain_out, ^{N{1'b1}});
      for (int i = 0; i < N; i++) begin
         prev = chain_out;
         @(negedge clk); chain_in[i] = 1'b0; settle();
         check("R5 walk down", chain_out, ~prev);
      end
      check("R6 end low", chain_out, 1'b0);
      // R5 / R8: random members in mode
      for (int i = 0; i < 200; i++) begin
         @(negedge clk); chain_in = {$urandom, $urandom, $urandom};
         strap_a = $urandom; strap_b = $urandom; pin_func = $urandom;
         settle();
         check_all("R5 R8 random");
      end
      // R2: exit via each strap
      @(negedge clk); chain_in = '0;
      rst_pulse(1'b1, 1'b0);
      check_all("R2 exit strap_a");
      rst_pulse(1'b0, 1'b0);
      check_all("R1 re-entry");
      rst_pulse(1'b0, 1'b1);
      check_all("R2 exit strap_b");
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); chain_in = {$urandom, $urandom, $urandom}; pin_func = $urandom;
         settle();
         check_all("R7 random off");
      end
      // R3: power-on reset leaves test mode
      rst_pulse(1'b0, 1'b0);
      check_all("R1 entry again");
      @(negedge clk); por = 1'b1; m_mode = 1'b0; settle();
      check_all("R3 por exit");
      @(negedge clk); por = 1'b0; settle();
      check_all("R3 por released");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule